// File: doc/BRIEF.md
# Dual-Domain Reset Release Unit

This block turns one external asynchronous reset and the lock indicator of a clock generator into a clean reset for each of two independent clock domains. Reset takes effect at once, with no clock edge needed. Release happens on a rising edge of each domain's own clock, and only after a guaranteed minimum number of that domain's cycles. This holds even when the incoming reset pulse is far shorter than one clock period.

The lock indicator is treated as asynchronous to every clock. While it is low, both domains are held in reset. When it rises, it passes through the same per-domain synchronizer as the external reset. Each domain has a two-stage release synchronizer followed by a down-counter built from ordinary flip-flops. The counter reloads to its full length whenever a reset source is active, and it counts down only while every source is inactive. Each domain also reports a ready flag, which is the inverse of its reset output.

Top module: `reset_release_unit`

## Requirements
- R1: While `extReset` is high or `lockIn` is low, `rstOutA` and `rstOutB` go high at once, without waiting for any clock edge, and stay high.
- R2: Suppose every reset source becomes inactive between two clock edges of a domain. With `STRETCH_x` set for that domain and `SYNC_STAGES` = 2, its reset output stays high through the next `STRETCH_x + 1` rising edges and falls on the `STRETCH_x + 2`-th rising edge. The change happens only just after that edge.
- R3: An `extReset` pulse shorter than one clock period, applied while a domain is out of reset, still gives that domain a full-length reset as defined in R2.
- R4: If a reset source becomes active again while a domain is counting down toward release, the count restarts from its full length. The release then comes the full R2 interval after the new pulse ends.
- R5: A drop of `lockIn` while `extReset` is low re-asserts reset in both domains. When `lockIn` rises again, the release follows the R2 timing.
- R6: Each domain counts only its own clock and uses its own stretch parameter (`STRETCH_A` and `STRETCH_B`, default 16, minimum 2). The two releases are therefore independent.
- R7: `readyA` is high exactly when `rstOutA` is low, and `readyB` is high exactly when `rstOutB` is low.
- R8: While the external reset is held from time zero, both reset outputs read 1 and both ready flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Clock of domain A |
| clkB | input | 1 | Clock of domain B |
| extReset | input | 1 | External reset, active high, asynchronous |
| lockIn | input | 1 | Clock generator lock indicator, asynchronous, high when locked |
| rstOutA | output | 1 | Reset for domain A, active high, released on a clkA edge |
| rstOutB | output | 1 | Reset for domain B, active high, released on a clkB edge |
| readyA | output | 1 | High when domain A is out of reset |
| readyB | output | 1 | High when domain B is out of reset |

## Verification
A counter that loads the wrong value, or that fails to reload on a new source, shows up directly at the ports. The reset output falls on an edge other than the `STRETCH + 2`-th after the sources clear, so the error appears within about twenty cycles of every release. A synchronizer stage that is missing or stuck shifts that falling edge by a whole cycle, or lets a sub-cycle glitch be missed entirely. A broken asynchronous set shows up as a reset output that is still low half a nanosecond after a source becomes active. The scoreboard therefore checks the output level just after every rising edge during each countdown, and checks the level within the glitch itself.

// File: rtl/rst_rel_pkg.sv
`timescale 1ns/1ps
package rst_rel_pkg;

  localparam int unsigned NUM_DOMAINS = 2;

  // strobes from the release control to the stretch datapath
  typedef struct packed {
    logic reload;     // hold counter at full length
    logic countDown;  // step counter toward zero
    logic drop;       // release the domain reset on this edge
  } stretchCmd_t;

  // counter status back to the control
  typedef struct packed {
    logic atFull;
    logic atOne;
    logic isZero;
  } stretchStat_t;

endpackage

// File: rtl/rst_release_ctrl.sv
`timescale 1ns/1ps
module rst_release_ctrl
  import rst_rel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         srcAsync,
  input  stretchStat_t stat,
  output stretchCmd_t  cmd
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncBusy;

  // set asynchronously by any source, cleared one stage per edge
  always_ff @(posedge clk or posedge srcAsync) begin
    if (srcAsync) syncChain <= '1;
    else          syncChain <= {syncChain[SYNC_STAGES-2:0], 1'b0};
  end

  assign syncBusy = syncChain[SYNC_STAGES-1];

  always_comb begin
    cmd.reload    = syncBusy;
    cmd.countDown = !syncBusy && !stat.isZero;
    cmd.drop      = !syncBusy && stat.atOne;
  end

  // the countdown always starts from the full length
  AST_FULL_AT_COUNT_START: assert property (@(posedge clk) disable iff (srcAsync)
    $fell(syncBusy) |-> stat.atFull); // R4

endmodule

// File: rtl/rst_stretch_path.sv
`timescale 1ns/1ps
module rst_stretch_path
  import rst_rel_pkg::*;
#(
  parameter int unsigned STRETCH = 16
) (
  input  logic         clk,
  input  logic         srcAsync,
  input  stretchCmd_t  cmd,
  output stretchStat_t stat,
  output logic         rstOut
);

  localparam int unsigned CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] FULL = CW'(STRETCH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge srcAsync) begin
    if (srcAsync)          cnt <= FULL;
    else if (cmd.reload)   cnt <= FULL;
    else if (cmd.countDown) cnt <= cnt - ONE;
  end

  always_ff @(posedge clk or posedge srcAsync) begin
    if (srcAsync)        rstOut <= 1'b1;
    else if (cmd.reload) rstOut <= 1'b1;
    else if (cmd.drop)   rstOut <= 1'b0;
  end

  always_comb begin
    stat.atFull = (cnt == FULL);
    stat.atOne  = (cnt == ONE);
    stat.isZero = (cnt == '0);
  end

  AST_HOLD_WHILE_COUNTING: assert property (@(posedge clk) disable iff (srcAsync)
    (cnt != '0) |-> rstOut); // R2
  AST_FALL_ONLY_AT_ONE: assert property (@(posedge clk) disable iff (srcAsync)
    $fell(rstOut) |-> ($past(cnt) == ONE)); // R2
  AST_IDLE_COUNT_EMPTY: assert property (@(posedge clk) disable iff (srcAsync)
    !rstOut |-> (cnt == '0)); // R3

endmodule

// File: rtl/reset_release_unit.sv
`timescale 1ns/1ps
module reset_release_unit
  import rst_rel_pkg::*;
#(
  parameter int unsigned STRETCH_A   = 16,
  parameter int unsigned STRETCH_B   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clkA,
  input  logic clkB,
  input  logic extReset,
  input  logic lockIn,
  output logic rstOutA,
  output logic rstOutB,
  output logic readyA,
  output logic readyB
);

  logic                   srcAsync;
  logic [NUM_DOMAINS-1:0] domClk;
  logic [NUM_DOMAINS-1:0] domRst;

  assign srcAsync = extReset | ~lockIn;
  assign domClk   = {clkB, clkA};

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    localparam int unsigned LEN = (d == 0) ? STRETCH_A : STRETCH_B;
    stretchCmd_t  cmd;
    stretchStat_t stat;

    rst_release_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .clk      (domClk[d]),
      .srcAsync (srcAsync),
      .stat     (stat),
      .cmd      (cmd)
    );

    rst_stretch_path #(.STRETCH(LEN)) u_path (
      .clk      (domClk[d]),
      .srcAsync (srcAsync),
      .cmd      (cmd),
      .stat     (stat),
      .rstOut   (domRst[d])
    );

    AST_LOCK_LOSS_HOLDS: assert property (@(posedge domClk[d]) disable iff (extReset)
      !lockIn |-> domRst[d]); // R5
  end

  assign rstOutA = domRst[0];
  assign rstOutB = domRst[1];
  assign readyA  = ~domRst[0];
  assign readyB  = ~domRst[1];

endmodule

// File: tb/sim_reset_release_unit.sv
`timescale 1ns/1ps
module sim_reset_release_unit;

  localparam int unsigned LEN_A = 16;
  localparam int unsigned LEN_B = 5;
  localparam int EDGES_A = LEN_A + 2;
  localparam int EDGES_B = LEN_B + 2;

  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic extReset, lockIn;
  logic rstOutA, rstOutB, readyA, readyB;

  int checks = 0;
  int errors = 0;

  typedef struct {int edges; string tag;} expT;
  expT qA[$];
  expT qB[$];
  int busyA = 0;
  int busyB = 0;

  always #2 clkA = ~clkA;   // 250 MHz
  always #3 clkB = ~clkB;

  reset_release_unit #(.STRETCH_A(LEN_A), .STRETCH_B(LEN_B)) u0 (
    .clkA(clkA), .clkB(clkB), .extReset(extReset), .lockIn(lockIn),
    .rstOutA(rstOutA), .rstOutB(rstOutB), .readyA(readyA), .readyB(readyB)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkDom(input int dom, input int expRst, input string tag);
    logic r, y;
    r = (dom == 0) ? rstOutA : rstOutB;
    y = (dom == 0) ? readyA : readyB;
    check(r == expRst, tag, r, expRst);
    check(y == !expRst, {tag, " R7 ready"}, y, !expRst);
  endtask

  // driver side: queue the expected release for both domains, wait for monitors
  task automatic expectRelease(input string tagA, input string tagB);
    expT a, b;
    a.edges = EDGES_A; a.tag = tagA;
    b.edges = EDGES_B; b.tag = tagB;
    qA.push_back(a);
    qB.push_back(b);
    wait (qA.size() == 0 && qB.size() == 0 && busyA == 0 && busyB == 0);
  endtask

  task automatic monitorDomain(input int dom);
    expT it;
    forever begin
      if (dom == 0) begin
        wait (qA.size() > 0); busyA = 1; it = qA.pop_front();
      end else begin
        wait (qB.size() > 0); busyB = 1; it = qB.pop_front();
      end
      for (int i = 1; i <= it.edges; i++) begin
        if (dom == 0) @(posedge clkA); else @(posedge clkB);
        #0.5;
        checkDom(dom, (i < it.edges) ? 1 : 0, it.tag);
      end
      if (dom == 0) busyA = 0; else busyB = 0;
    end
  endtask

  initial monitorDomain(0);
  initial monitorDomain(1);

  initial begin
    repeat (50000) @(posedge clkA);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    extReset = 1'b1;
    lockIn   = 1'b0;
    #1;
    checkDom(0, 1, "R8 reset state A");
    checkDom(1, 1, "R8 reset state B");

    // lock comes up while the external reset is still held
    @(negedge clkA); lockIn = 1'b1;
    repeat (3) @(negedge clkA);
    checkDom(0, 1, "R1 held by extReset A");
    checkDom(1, 1, "R1 held by extReset B");
    extReset = 1'b0;
    expectRelease("R2 release A", "R6 release B own length");
    #1;
    checkDom(0, 0, "R7 out of reset A");
    checkDom(1, 0, "R7 out of reset B");

    // short glitch, half a nanosecond wide
    @(negedge clkA); extReset = 1'b1;
    #0.25;
    checkDom(0, 1, "R1 async assert A");
    checkDom(1, 1, "R1 async assert B");
    #0.25; extReset = 1'b0;
    expectRelease("R3 glitch full length A", "R3 glitch full length B");

    // loss of lock
    @(negedge clkA); lockIn = 1'b0;
    #0.5;
    checkDom(0, 1, "R5 lock loss A");
    checkDom(1, 1, "R5 lock loss B");
    repeat (5) @(negedge clkA);
    checkDom(0, 1, "R5 lock still low A");
    checkDom(1, 1, "R5 lock still low B");
    lockIn = 1'b1;
    expectRelease("R5 relock A", "R5 relock B");

    // re-assert in the middle of domain A's countdown
    @(negedge clkA); extReset = 1'b1;
    repeat (2) @(negedge clkA);
    extReset = 1'b0;
    repeat (10) @(negedge clkA);
    checkDom(0, 1, "R4 mid countdown A");
    extReset = 1'b1;
    #0.25; extReset = 1'b0;
    expectRelease("R4 restart full A", "R4 restart full B");

    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule